// File: doc/BRIEF.md
# Dual-Port Semaphore Token Bank

This block holds a small bank of hardware semaphore flags that two independent processor ports, left and right, share. Software on either side uses a flag as a token that stands for a shared resource. A side asks for the token by writing 0 and gives it back by writing 1. It then reads the flag to learn whether it holds the token. The flags live in their own address space, apart from any memory. The block puts no hardware lock on any resource. It only decides who holds each token, so neither processor ever waits.

Each flag keeps one request latch for each side. A request that arrives while the other side holds the token stays pending, and ownership passes straight to that side when the holder lets go. Each port also has a read register. It captures the addressed flag once, when the port's select and output enable both become active, and holds that value until one of them drops. A write from the other side therefore cannot disturb a read that is in progress. The circuit is synchronous to one clock. A write takes effect at the clock edge where it is presented, and a read captures at the edge where select and output enable are first seen active.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every flag is free. A read on either port of any flag returns all ones, and while a port is not reading, its `xDrive` output is 0 and its `xDout` output is all zeros.
- R2: The flag is chosen by address bits [2:0] alone. With select asserted, all higher address bits have no effect.
- R3: A write happens only at a clock edge where select is low and `xRwN` is low. Only data bit 0 counts (0 means request, 1 means release), and data bits 8..1 are ignored.
- R4: A side that writes 0 to a free flag becomes its owner. It reads all zeros, and the other side reads all ones.
- R5: A 0 written by the non-owner is kept as a pending request. The non-owner keeps reading all ones, and the owner keeps the token.
- R6: When the owner writes 1, the flag becomes free (all ones on both sides) if the other side has no pending request. If the other side has one, that side becomes the owner at once.
- R7: A read drives the flag's value onto all 9 data bits, with `xDrive` at 1.
- R8: A port's read value is captured at the first clock edge where its select and output enable are both low. It stays frozen, against both address changes and writes from the other side, until either signal goes high. The next edge after that returns `xDrive` to 0.
- R9: When both sides write 0 to a free flag at the same edge, the left side gets the token and the right side's request stays pending.
- R10: The owner rewriting 0 changes nothing. A 1 written by a side that neither owns the flag nor has a pending request changes nothing. A 1 written by a side with a pending request only cancels that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lSemN | input | 1 | Left semaphore select, active low |
| lOeN | input | 1 | Left output enable, active low |
| lRwN | input | 1 | Left read/write, 1 = read, 0 = write |
| lAddr | input | 13 | Left address; bits [2:0] pick the flag |
| lDin | input | 9 | Left write data; bit 0 used |
| lDout | output | 9 | Left read data |
| lDrive | output | 1 | Left read data valid |
| rSemN | input | 1 | Right semaphore select, active low |
| rOeN | input | 1 | Right output enable, active low |
| rRwN | input | 1 | Right read/write, 1 = read, 0 = write |
| rAddr | input | 13 | Right address; bits [2:0] pick the flag |
| rDin | input | 9 | Right write data; bit 0 used |
| rDout | output | 9 | Right read data |
| rDrive | output | 1 | Right read data valid |

## Verification
A write presented in a cycle changes the token state at that cycle's rising edge. The earliest read that can see the change captures at the following edge, and its data appears just after that edge. The bench drives every access at the falling edge. It samples read data at the next falling edge, half a cycle after the capture edge, and drops select before the next access so that each read starts a fresh capture. The freeze checks hold select and output enable low across several edges and sample at each falling edge. The drop of `xDrive` is checked one full edge after output enable or select is released.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // strobes from one port's control to the flag datapath
  typedef struct packed {
    logic wr;     // write to the addressed flag at this edge
    logic wrBit;  // value written (0 = request, 1 = release)
    logic cap;    // capture the addressed flag into the read register
    logic held;   // read register currently presented on the bus
  } portStrobe_t;

endpackage

// File: rtl/sem_port_ctrl.sv
module sem_port_ctrl
  import sem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              semN,
  input  logic              oeN,
  input  logic              rwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output portStrobe_t       stb,
  output logic [IDX_W-1:0]  idx
);

  logic holdQ;
  logic readActive;

  assign readActive = !semN && !oeN;
  assign idx        = addr[IDX_W-1:0];

  always_comb begin
    stb.wr    = !semN && !rwN;
    stb.wrBit = din[0];
    stb.cap   = readActive && !holdQ;
    stb.held  = holdQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdQ <= 1'b0;
    else       holdQ <= readActive;
  end

  // R8: releasing select or output enable ends the held read at the next edge
  assert_hold_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (semN || oeN) |=> !stb.held);

  // R8: a capture always leads to a held read at the next edge
  assert_cap_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.cap |=> stb.held);

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3,
  parameter int DATA_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       lStb,
  input  logic [IDX_W-1:0]  lIdx,
  input  portStrobe_t       rStb,
  input  logic [IDX_W-1:0]  rIdx,
  output logic [DATA_W-1:0] lDout,
  output logic              lDrive,
  output logic [DATA_W-1:0] rDout,
  output logic              rDrive
);

  localparam int NPORT = 2;

  logic [NUM_FLAGS-1:0] wantLQ, wantRQ;
  owner_e               ownQ [NUM_FLAGS];
  logic [NUM_FLAGS-1:0] lView, rView;   // 1 = not owned by this side

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic   hitL, hitR;
    logic   nextWantL, nextWantR;
    owner_e nextOwn;

    assign hitL      = lStb.wr && (lIdx == IDX_W'(g));
    assign hitR      = rStb.wr && (rIdx == IDX_W'(g));
    assign nextWantL = hitL ? !lStb.wrBit : wantLQ[g];
    assign nextWantR = hitR ? !rStb.wrBit : wantRQ[g];

    always_comb begin
      nextOwn = ownQ[g];
      unique case (ownQ[g])
        OWN_NONE: begin
          if (nextWantL)      nextOwn = OWN_LEFT;   // fixed left priority on ties
          else if (nextWantR) nextOwn = OWN_RIGHT;
        end
        OWN_LEFT:  if (!nextWantL) nextOwn = nextWantR ? OWN_RIGHT : OWN_NONE;
        OWN_RIGHT: if (!nextWantR) nextOwn = nextWantL ? OWN_LEFT  : OWN_NONE;
        default:   nextOwn = OWN_NONE;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wantLQ[g] <= 1'b0;
        wantRQ[g] <= 1'b0;
        ownQ[g]   <= OWN_NONE;
      end else begin
        wantLQ[g] <= nextWantL;
        wantRQ[g] <= nextWantR;
        ownQ[g]   <= nextOwn;
      end
    end

    assign lView[g] = (ownQ[g] != OWN_LEFT);
    assign rView[g] = (ownQ[g] != OWN_RIGHT);

    assert_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
      (ownQ[g] == OWN_NONE && hitL && !lStb.wrBit) |=> ownQ[g] == OWN_LEFT);

    assert_lockout_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ownQ[g] == OWN_LEFT && !hitL && hitR) |=> ownQ[g] == OWN_LEFT);

    assert_handoff_R6: assert property (@(posedge clk) disable iff (!rstN)
      (ownQ[g] == OWN_LEFT && hitL && lStb.wrBit && nextWantR) |=> ownQ[g] == OWN_RIGHT);

    assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rstN)
      (ownQ[g] == OWN_NONE && hitL && !lStb.wrBit && hitR && !rStb.wrBit)
      |=> (ownQ[g] == OWN_LEFT && wantRQ[g]));

    assert_cancel_R10: assert property (@(posedge clk) disable iff (!rstN)
      (ownQ[g] == OWN_LEFT && wantRQ[g] && hitR && rStb.wrBit && !hitL)
      |=> (ownQ[g] == OWN_LEFT && !wantRQ[g]));
  end

  // read registers, one per port
  portStrobe_t          pStb  [NPORT];
  logic [IDX_W-1:0]     pIdx  [NPORT];
  logic [NUM_FLAGS-1:0] pView [NPORT];
  logic [DATA_W-1:0]    pDout [NPORT];

  assign pStb[0]  = lStb;
  assign pStb[1]  = rStb;
  assign pIdx[0]  = lIdx;
  assign pIdx[1]  = rIdx;
  assign pView[0] = lView;
  assign pView[1] = rView;

  for (genvar p = 0; p < NPORT; p++) begin : gRead
    logic bitQ;

    always_ff @(posedge clk) begin
      if (!rstN)            bitQ <= 1'b1;
      else if (pStb[p].cap) bitQ <= pView[p][pIdx[p]];
    end

    assign pDout[p] = pStb[p].held ? {DATA_W{bitQ}} : '0;

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
      pStb[p].held |=> (!pStb[p].held || $stable(bitQ)));
  end

  assign lDout  = pDout[0];
  assign rDout  = pDout[1];
  assign lDrive = lStb.held;
  assign rDrive = rStb.held;

endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lSemN,
  input  logic              lOeN,
  input  logic              lRwN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lDin,
  output logic [DATA_W-1:0] lDout,
  output logic              lDrive,
  input  logic              rSemN,
  input  logic              rOeN,
  input  logic              rRwN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rDin,
  output logic [DATA_W-1:0] rDout,
  output logic              rDrive
);

  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1;

  portStrobe_t      lStb, rStb;
  logic [IDX_W-1:0] lIdx, rIdx;

  sem_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uCtrlL (
    .clk(clk), .rstN(rstN), .semN(lSemN), .oeN(lOeN), .rwN(lRwN),
    .addr(lAddr), .din(lDin), .stb(lStb), .idx(lIdx));

  sem_port_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) uCtrlR (
    .clk(clk), .rstN(rstN), .semN(rSemN), .oeN(rOeN), .rwN(rRwN),
    .addr(rAddr), .din(rDin), .stb(rStb), .idx(rIdx));

  sem_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W)) uBank (
    .clk(clk), .rstN(rstN),
    .lStb(lStb), .lIdx(lIdx), .rStb(rStb), .rIdx(rIdx),
    .lDout(lDout), .lDrive(lDrive), .rDout(rDout), .rDrive(rDrive));

endmodule

// File: tb/sim_sem_token_bank.sv
module sim_sem_token_bank;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lSemN = 1'b1, lOeN = 1'b1, lRwN = 1'b1;
  logic rSemN = 1'b1, rOeN = 1'b1, rRwN = 1'b1;
  logic [12:0] lAddr = '0, rAddr = '0;
  logic [8:0]  lDin = '0, rDin = '0;
  logic [8:0]  lDout, rDout;
  logic        lDrive, rDrive;

  int nChecks = 0;
  int nFails  = 0;

  // reference model: owner 0 free, 1 left, 2 right; pending requests per side
  int own [8];
  bit pendL [8];
  bit pendR [8];

  always #4 clk = ~clk;

  sem_token_bank u0 (
    .clk(clk), .rstN(rstN),
    .lSemN(lSemN), .lOeN(lOeN), .lRwN(lRwN), .lAddr(lAddr), .lDin(lDin),
    .lDout(lDout), .lDrive(lDrive),
    .rSemN(rSemN), .rOeN(rOeN), .rRwN(rRwN), .rAddr(rAddr), .rDin(rDin),
    .rDout(rDout), .rDrive(rDrive));

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply one edge of writes to the model (bL/bR = 1 when that side writes)
  task automatic modelEdge(input int i, input bit wL, input bit vL, input bit wR, input bit vR);
    bit nl, nr;
    nl = wL ? !vL : (own[i] == 1 || pendL[i]);
    nr = wR ? !vR : (own[i] == 2 || pendR[i]);
    case (own[i])
      0: own[i] = nl ? 1 : (nr ? 2 : 0);
      1: if (!nl) own[i] = nr ? 2 : 0;
      default: if (!nr) own[i] = nl ? 1 : 0;
    endcase
    pendL[i] = nl && own[i] != 1;
    pendR[i] = nr && own[i] != 2;
  endtask

  function automatic bit viewOf(input bit side, input int i);
    return side ? (own[i] != 2) : (own[i] != 1);
  endfunction

  // one write cycle on one side; upper data bits deliberately opposite to bit 0
  task automatic wr(input bit side, input int i, input bit v, input logic [9:0] hi);
    @(negedge clk);
    if (!side) begin
      lSemN = 0; lRwN = 0; lOeN = 1; lAddr = {hi, i[2:0]}; lDin = v ? 9'h001 : 9'h1FE;
    end else begin
      rSemN = 0; rRwN = 0; rOeN = 1; rAddr = {hi, i[2:0]}; rDin = v ? 9'h001 : 9'h1FE;
    end
    @(posedge clk);
    modelEdge(i, !side, v, side, v);
    @(negedge clk);
    lSemN = 1; lRwN = 1; rSemN = 1; rRwN = 1;
  endtask

  task automatic wrBoth(input int i, input bit vL, input bit vR);
    @(negedge clk);
    lSemN = 0; lRwN = 0; lAddr = {10'h0, i[2:0]}; lDin = {8'h0, vL};
    rSemN = 0; rRwN = 0; rAddr = {10'h3FF, i[2:0]}; rDin = {8'h0, vR};
    @(posedge clk);
    modelEdge(i, 1'b1, vL, 1'b1, vR);
    @(negedge clk);
    lSemN = 1; lRwN = 1; rSemN = 1; rRwN = 1;
  endtask

  task automatic rd(input bit side, input int i, input logic [9:0] hi, input string req);
    bit e;
    @(negedge clk);
    if (!side) begin lSemN = 0; lOeN = 0; lRwN = 1; lAddr = {hi, i[2:0]}; end
    else       begin rSemN = 0; rOeN = 0; rRwN = 1; rAddr = {hi, i[2:0]}; end
    @(posedge clk);
    e = viewOf(side, i);
    @(negedge clk);
    if (!side) chk(req, {lDrive, lDout}, {1'b1, {9{e}}});
    else       chk(req, {rDrive, rDout}, {1'b1, {9{e}}});
    lSemN = 1; lOeN = 1; rSemN = 1; rOeN = 1;
    @(posedge clk);
  endtask

  task automatic rdBoth(input int i, input string req);
    rd(1'b0, i, 10'h155, req);
    rd(1'b1, i, 10'h2AA, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin own[i] = 0; pendL[i] = 0; pendR[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    chk("R1 idle left", {lDrive, lDout}, 10'h000);
    chk("R1 idle right", {rDrive, rDout}, 10'h000);
    for (int i = 0; i < 8; i++) rdBoth(i, "R1 reset free");

    // R3: write with select high, and read-cycle with oe, must not claim
    @(negedge clk);
    lSemN = 1; lRwN = 0; lAddr = 13'd2; lDin = 9'h000;
    @(posedge clk);
    @(negedge clk) lRwN = 1;
    rdBoth(2, "R3 deselected write ignored");

    for (int i = 0; i < 8; i++) begin
      int nb;
      nb = (i + 1) % 8;
      wr(0, i, 0, 10'h3FF);                 rdBoth(i,  "R4 R2 left claims free");
      rdBoth(nb, "R2 neighbour untouched");
      wr(1, i, 0, 10'h0F0);                 rdBoth(i,  "R5 right pending");
      wr(0, i, 0, 10'h001);                 rdBoth(i,  "R10 owner rewrite 0");
      wr(0, i, 1, 10'h000);                 rdBoth(i,  "R6 handoff to right R7");
      wr(0, i, 1, 10'h2AA);                 rdBoth(i,  "R10 idle release ignored");
      wr(0, i, 0, 10'h000);                 rdBoth(i,  "R5 left pending");
      wr(1, i, 1, 10'h000);                 rdBoth(i,  "R6 handoff to left");
      wr(1, i, 0, 10'h000);
      wr(1, i, 1, 10'h000);                 rdBoth(i,  "R10 cancel pending");
      wr(0, i, 1, 10'h000);                 rdBoth(i,  "R6 release to free");
      wrBoth(i, 0, 0);                      rdBoth(i,  "R9 tie goes left");
      wr(0, i, 1, 10'h000);                 rdBoth(i,  "R9 pending right gets it");
      wr(1, i, 1, 10'h000);                 rdBoth(i,  "R6 right releases");
    end

    // R8: freeze against the other side's write and against address change
    wr(1, 5, 0, 10'h000);
    wr(0, 5, 0, 10'h000);
    @(negedge clk);
    lSemN = 0; lOeN = 0; lRwN = 1; lAddr = 13'd5;
    @(posedge clk);
    @(negedge clk);
    chk("R8 held ones", {lDrive, lDout}, 10'h3FF);
    rSemN = 0; rRwN = 0; rAddr = 13'd5; rDin = 9'h001;
    @(posedge clk);
    modelEdge(5, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rSemN = 1; rRwN = 1;
    chk("R8 frozen across right release", {lDrive, lDout}, 10'h3FF);
    lOeN = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 oe release drops drive", {lDrive, lDout}, 10'h000);
    lOeN = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R8 R6 recapture shows ownership", {lDrive, lDout}, 10'h200);
    lAddr = 13'd6;
    @(posedge clk);
    @(negedge clk);
    chk("R8 frozen across address change", {lDrive, lDout}, 10'h200);
    lSemN = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 select release drops drive", {lDrive, lDout}, 10'h000);
    lOeN = 1;
    rd(0, 6, 10'h000, "R8 new read sees flag 6");
    rd(0, 5, 10'h000, "R6 left owns flag 5");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule